// File: doc/BRIEF.md
# Dual-Timer Pixel Hit Coincidence

Each pixel of a triggered tracking sensor must remember a discriminator hit until the global trigger decision arrives, which comes several microseconds later. This block holds that memory. A rising edge on the asynchronous discriminator line is synchronised and loads a delay timer with the programmed latency. The timer counts down to zero and then opens a two-clock window. If the global trigger is seen inside that window, the timer's hit flag is raised and held until the column scanner acknowledges it. If no trigger arrives in the window, the timer simply goes back to idle.

The pixel has more than one timer, two by default. A hit that arrives while the first timer is busy is taken by the next free one, so a second particle inside the latency is not lost. A hit that finds every timer busy is dropped, and a sticky loss bit records the drop. All timing is counted in cycles of the pixel clock.

Top module: `dual_timer_pixel`

## Requirements
- R1: After reset, all hit flags and the loss bit read 0.
- R2: The discriminator input passes through a two-flop synchroniser. Only a rising edge starts a timer, and one edge starts at most one timer. A level held high starts nothing further.
- R3: A new hit goes to the lowest-numbered idle timer. A timer is idle only when it is neither counting, in its window, nor holding a flag.
- R4: A hit that arrives while timer 0 is busy is taken by timer 1, which then runs independently of timer 0.
- R5: Let k be the first clock edge at which the discriminator is sampled high, and L the latency. A trigger sampled high at edge k+L+5 or at edge k+L+6 sets that timer's flag (bit i of hit_o for timer i) after that edge.
- R6: A trigger sampled at any other edge sets no flag. A timer whose window closes without a trigger is idle again after edge k+L+6.
- R7: A set flag stays high until its ack bit is sampled high, and it clears after that edge. While its flag is set, the timer takes no new hit.
- R8: A rising edge that arrives while every timer is busy is discarded and sets ovf_o, which stays high until reset.
- R9: The latency is sampled once, at edge k+2 when the timer leaves idle. Later changes to latency_i do not move that timer's window.
- R10: Latency 0 and the largest latency of 127 both follow the timing of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disc_i | input | 1 | Discriminator output, asynchronous |
| trig_i | input | 1 | Global trigger, synchronous |
| latency_i | input | CNT_W | Latency preset in clock cycles |
| ack_i | input | NUM_TMR | Scanner acknowledge, one bit per timer |
| hit_o | output | NUM_TMR | Latched coincidence flag, one bit per timer |
| ovf_o | output | 1 | Sticky hit-loss indicator |

## Verification
The bench builds the block with its default parameters: a 7-bit counter, two timers and a two-cycle window. At these values the full latency range, up to 127, can be covered in a short run. Two timers are also few enough that both can be filled and the loss path reached with three closely spaced edges. A behavioural model in the bench works out each timer's window edges from the hit time and the latency it captured. The bench compares the model with both flags and the loss bit on every cycle.

// File: rtl/pixel_coinc_pkg.sv
package pixel_coinc_pkg;
  typedef enum logic [2:0] {
    TMR_IDLE,
    TMR_LOAD,
    TMR_COUNT,
    TMR_WINDOW,
    TMR_HELD
  } tmr_state_e;
endpackage

// File: rtl/pixel_edge_sync.sv
module pixel_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s2_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s2_d_q <= 1'b0;
    end else begin
      s1_q   <= async_i;
      s2_q   <= s1_q;
      s2_d_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s2_d_q;
endmodule

// File: rtl/pixel_grant_arbiter.sv
module pixel_grant_arbiter #(
  parameter int NUM_TMR = 2
) (
  input  logic               req_i,
  input  logic [NUM_TMR-1:0] busy_i,
  output logic [NUM_TMR-1:0] grant_o,
  output logic               drop_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (req_i && !busy_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign drop_o = req_i & (&busy_i);
endmodule

// File: rtl/pixel_delay_timer.sv
module pixel_delay_timer
  import pixel_coinc_pkg::*;
#(
  parameter int CNT_W   = 7,
  parameter int WIN_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] latency_i,
  input  logic             trig_i,
  input  logic             ack_i,
  output logic             busy_o,
  output logic             hit_o
);
  localparam int WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

  tmr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIN_W-1:0] wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
      wcnt_q  <= '0;
    end else begin
      case (state_q)
        TMR_IDLE: begin
          if (start_i) begin
            state_q <= TMR_LOAD;
            cnt_q   <= latency_i;
          end
        end
        TMR_LOAD: state_q <= TMR_COUNT;
        TMR_COUNT: begin
          if (cnt_q == '0) begin
            state_q <= TMR_WINDOW;
            wcnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        TMR_WINDOW: begin
          if (trig_i)                state_q <= TMR_HELD;
          else if (wcnt_q == WIN_LAST) state_q <= TMR_IDLE;
          else                       wcnt_q  <= wcnt_q + 1'b1;
        end
        TMR_HELD: begin
          if (ack_i) state_q <= TMR_IDLE;
        end
        default: state_q <= TMR_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != TMR_IDLE);
  assign hit_o  = (state_q == TMR_HELD);
endmodule

// File: rtl/dual_timer_pixel.sv
module dual_timer_pixel #(
  parameter int CNT_W   = 7,
  parameter int NUM_TMR = 2,
  parameter int WIN_CYC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               disc_i,
  input  logic               trig_i,
  input  logic [CNT_W-1:0]   latency_i,
  input  logic [NUM_TMR-1:0] ack_i,
  output logic [NUM_TMR-1:0] hit_o,
  output logic               ovf_o
);
  logic               rise;
  logic               drop;
  logic [NUM_TMR-1:0] busy;
  logic [NUM_TMR-1:0] grant;
  logic               ovf_q;

  pixel_edge_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (disc_i),
    .rise_o  (rise)
  );

  pixel_grant_arbiter #(.NUM_TMR(NUM_TMR)) u_arb (
    .req_i   (rise),
    .busy_i  (busy),
    .grant_o (grant),
    .drop_o  (drop)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    pixel_delay_timer #(.CNT_W(CNT_W), .WIN_CYC(WIN_CYC)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (grant[g]),
      .latency_i (latency_i),
      .trig_i    (trig_i),
      .ack_i     (ack_i[g]),
      .busy_o    (busy[g]),
      .hit_o     (hit_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/pixel_coinc_checker.sv
module pixel_coinc_checker #(
  parameter int NUM_TMR = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               trig_i,
  input logic [NUM_TMR-1:0] ack_i,
  input logic [NUM_TMR-1:0] hit_o,
  input logic               ovf_o,
  input logic [NUM_TMR-1:0] grant_i
);
  a_r2_one_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
    a_r7_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o[g] && !ack_i[g]) |=> hit_o[g]);

    a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o[g] && ack_i[g]) |=> !hit_o[g]);

    a_r5_flag_needs_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hit_o[g]) |-> $past(trig_i));

    a_r7_no_grant_while_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o[g] |-> !grant_i[g]);
  end
endmodule

bind dual_timer_pixel pixel_coinc_checker #(.NUM_TMR(NUM_TMR)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .trig_i  (trig_i),
  .ack_i   (ack_i),
  .hit_o   (hit_o),
  .ovf_o   (ovf_o),
  .grant_i (grant)
);

// File: tb/dual_timer_pixel_tb_top.sv
module dual_timer_pixel_tb_top;
  localparam int CNT_W = 7;
  localparam int NT    = 2;
  localparam int WIN   = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             disc = 1'b0;
  logic             trig = 1'b0;
  logic [CNT_W-1:0] latency = '0;
  logic [NT-1:0]    ack = '0;
  logic [NT-1:0]    hit;
  logic             ovf;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  dual_timer_pixel #(.CNT_W(CNT_W), .NUM_TMR(NT), .WIN_CYC(WIN)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .disc_i    (disc),
    .trig_i    (trig),
    .latency_i (latency),
    .ack_i     (ack),
    .hit_o     (hit),
    .ovf_o     (ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: timers described by start edge and captured latency
  int       n_edge;
  bit [3:0] hist;
  bit       m_busy [NT];
  bit       m_held [NT];
  int       m_start[NT];
  int       m_lat  [NT];
  bit       m_ovf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_edge = 0; hist = '0; m_ovf = 0;
      for (int t = 0; t < NT; t++) begin
        m_busy[t] = 0; m_held[t] = 0; m_start[t] = 0; m_lat[t] = 0;
      end
    end else begin
      bit old_busy[NT];
      bit rise;
      bit taken;
      n_edge++;
      rise = hist[1] && !hist[2];
      for (int t = 0; t < NT; t++) old_busy[t] = m_busy[t];
      for (int t = 0; t < NT; t++) begin
        if (m_held[t]) begin
          if (ack[t]) begin m_held[t] = 0; m_busy[t] = 0; end
        end else if (m_busy[t]) begin
          int w0;
          w0 = m_start[t] + m_lat[t] + 3;
          if ((n_edge == w0 || n_edge == w0 + WIN - 1) && trig) m_held[t] = 1;
          else if (n_edge == w0 + WIN - 1) m_busy[t] = 0;
        end
      end
      if (rise) begin
        taken = 0;
        for (int t = 0; t < NT; t++) begin
          if (!taken && !old_busy[t]) begin
            taken = 1; m_busy[t] = 1; m_start[t] = n_edge; m_lat[t] = int'(latency);
          end
        end
        if (!taken) m_ovf = 1;
      end
      hist = {hist[2:0], disc};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NT-1:0] m_hit;
      for (int t = 0; t < NT; t++) m_hit[t] = m_held[t];
      chk(hit === m_hit, cur_req, "hit_o vs model", int'(hit), int'(m_hit));
      chk(ovf === m_ovf, cur_req, "ovf_o vs model", int'(ovf), int'(m_ovf));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // single hit at j=0 (two cycles high), trigger at edge k+L+5+off
  task automatic one_hit(input int lat, input int off);
    latency = CNT_W'(lat);
    for (int j = 0; j <= lat + 8; j++) begin
      @(negedge clk);
      disc = (j < 2);
      trig = (j == lat + 5 + off);
    end
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic do_ack(input logic [NT-1:0] a);
    @(negedge clk); ack = a;
    @(negedge clk); ack = '0;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    cur_req = "R1";
    chk(hit == '0, "R1", "hit_o in reset", int'(hit), 0);
    chk(ovf == 1'b0, "R1", "ovf_o in reset", int'(ovf), 0);
    rst_n = 1'b1;
    cyc(2);
    chk(hit == '0 && ovf == 1'b0, "R1", "outputs after reset", int'({ovf, hit}), 0);

    cur_req = "R5";
    one_hit(10, 0);
    chk(hit == 2'b01, "R5", "trigger at first window edge", int'(hit), 1);
    cur_req = "R7";
    cyc(3);
    chk(hit == 2'b01, "R7", "flag held without ack", int'(hit), 1);
    do_ack(2'b01);
    chk(hit == 2'b00, "R7", "flag cleared by ack", int'(hit), 0);

    cur_req = "R5";
    one_hit(10, 1);
    chk(hit == 2'b01, "R5", "trigger at second window edge", int'(hit), 1);
    do_ack(2'b11);

    cur_req = "R6";
    one_hit(10, -1);
    chk(hit == 2'b00, "R6", "trigger one edge early", int'(hit), 0);
    one_hit(10, 2);
    chk(hit == 2'b00, "R6", "trigger one edge late", int'(hit), 0);
    cyc(2);

    cur_req = "R4";
    latency = CNT_W'(10);
    for (int j = 0; j <= 24; j++) begin
      @(negedge clk);
      disc = (j < 2) || (j >= 4 && j < 6);
      trig = (j == 15) || (j == 19);
    end
    @(negedge clk); trig = 1'b0;
    chk(hit == 2'b11, "R4", "both timers flagged", int'(hit), 3);
    do_ack(2'b10);
    chk(hit == 2'b01, "R7", "only timer 1 acknowledged", int'(hit), 1);

    cur_req = "R3";
    one_hit(4, 0);
    chk(hit == 2'b11, "R3", "hit taken by idle timer 1", int'(hit), 3);

    cur_req = "R8";
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      disc = (j < 2);
    end
    chk(ovf == 1'b1, "R8", "loss with both timers held", int'(ovf), 1);
    chk(hit == 2'b11, "R8", "dropped hit leaves flags", int'(hit), 3);
    do_ack(2'b11);
    cyc(3);
    chk(ovf == 1'b1, "R8", "loss bit sticky after ack", int'(ovf), 1);
    chk(hit == 2'b00, "R8", "flags cleared", int'(hit), 0);

    cur_req = "R1";
    @(negedge clk); rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    chk(ovf == 1'b0 && hit == '0, "R1", "reset clears loss bit", int'({ovf, hit}), 0);

    cur_req = "R2";
    latency = CNT_W'(3);
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      disc = 1'b1;
      trig = (j == 8) || (j == 20);
    end
    @(negedge clk); trig = 1'b0; disc = 1'b0;
    chk(hit == 2'b01, "R2", "level high starts one timer", int'(hit), 1);
    chk(ovf == 1'b0, "R2", "no loss from held level", int'(ovf), 0);
    do_ack(2'b11);
    cyc(3);

    cur_req = "R9";
    latency = CNT_W'(20);
    for (int j = 0; j <= 30; j++) begin
      @(negedge clk);
      latency = (j < 5) ? CNT_W'(20) : CNT_W'(2);
      disc = (j < 2);
      trig = (j == 25);
    end
    @(negedge clk); trig = 1'b0;
    chk(hit == 2'b01, "R9", "latency captured at start", int'(hit), 1);
    do_ack(2'b11);

    cur_req = "R10";
    one_hit(0, 0);
    chk(hit == 2'b01, "R10", "zero latency", int'(hit), 1);
    do_ack(2'b11);
    one_hit(127, 1);
    chk(hit == 2'b01, "R10", "largest latency", int'(hit), 1);
    do_ack(2'b11);
    cyc(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule